// File: doc/BRIEF.md
# Paged Address Translation Unit with Associative Lookup Buffer

This block turns a 13-bit byte virtual address into a 12-bit physical address for a small paged memory. The top three address bits select one of eight 1024-byte virtual pages. The ten low bits are the offset within the page, and they pass through unchanged. The physical address places a 2-bit frame number above that same offset, so there are four frames.

The page number is first compared against a small fully associative buffer that holds recent translations. A hit answers one cycle after the request is accepted. On a miss, the unit reads its internal eight-entry page table during one extra cycle. If the entry is resident, the unit loads the translation into the buffer and answers with the address. If it is not resident, the unit answers with a fault, and the requester retries the whole access once the page has been made resident.

Software fills and invalidates page-table entries through a separate write port. Any write also removes a cached copy of the same page from the buffer. Only one request is in flight at a time.

Top module: `xlate_unit`

## Requirements
- R1: A successful response drives rsp_paddr[9:0] equal to req_vaddr[9:0] and rsp_paddr[11:10] equal to the frame mapped to page req_vaddr[12:10]; for example, with page 5 mapped to frame 1, address 0x1553 yields 0x553.
- R2: When the page is held in the lookup buffer, rsp_valid pulses for one cycle, on the cycle after the accepting clock edge.
- R3: On a buffer miss, rsp_valid pulses on the second cycle after acceptance. A successful miss loads the translation into the buffer, so the next access to that page behaves as a hit.
- R4: If the page-table entry of a missed page has its valid bit at 0, the response has rsp_fault=1 and rsp_paddr=0.
- R5: A fault is not cached. After the entry is written as valid, retrying the same address succeeds with miss latency.
- R6: A page-table write (pt_we=1) removes any buffer entry whose tag equals pt_page. A later access to that page misses and returns the newly written frame.
- R7: The buffer has 4 entries that are replaced in round-robin order. After misses on five distinct pages with an empty buffer, the first of those pages misses again and the second still hits.
- R8: After reset, req_ready=1, rsp_valid=0, and every page faults until it is written.
- R9: While a miss is being resolved, req_ready is 0, so only one request is in flight.
- R10: A page-table write with pt_valid=0 makes later accesses to that page fault, even if the page was cached in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 13 | Virtual byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Page is not resident |
| rsp_paddr | output | 12 | Physical address, zero when faulting |
| pt_we | input | 1 | Page-table write strobe |
| pt_page | input | 3 | Page number being written |
| pt_valid | input | 1 | Resident bit written to the entry |
| pt_frame | input | 2 | Frame number written to the entry |

## Verification
A wrong buffer state shows up at the ports in one of two ways. A lost or stale entry changes response latency from one cycle to two, or the reverse. A stale entry that survives a page-table write returns the old frame on the very next access. For that reason the bench predicts the latency of every request, as well as the address or fault, from a model of the round-robin buffer. Page-table corruption appears as a wrong frame or an unexpected fault on the first miss to that page, which the bench triggers by sweeping every page after every batch of table writes.

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int OFF_W = 10,
  parameter int PG_W  = 3,
  parameter int FR_W  = 2,
  parameter int TLB_N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PG_W+OFF_W-1:0] req_vaddr,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [FR_W+OFF_W-1:0] rsp_paddr,
  input  logic                  pt_we,
  input  logic [PG_W-1:0]       pt_page,
  input  logic                  pt_valid,
  input  logic [FR_W-1:0]       pt_frame
);
  localparam int VA_W = PG_W + OFF_W;
  localparam int PT_N = 1 << PG_W;
  localparam int RR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [TLB_N-1:0] tv;
  logic [PG_W-1:0]  tag [TLB_N];
  logic [FR_W-1:0]  tfr [TLB_N];
  logic [PT_N-1:0]  pv;
  logic [FR_W-1:0]  pfr [PT_N];
  logic             walking;
  logic [VA_W-1:0]  held;
  logic [RR_W-1:0]  rr;
  logic [TLB_N-1:0] hitv;
  logic [FR_W-1:0]  hfr;

  wire [PG_W-1:0] rpage  = req_vaddr[VA_W-1:OFF_W];
  wire [PG_W-1:0] hpage  = held[VA_W-1:OFF_W];
  wire            accept = req_valid && req_ready;
  wire            hit    = |hitv;
  wire            refill = walking && pv[hpage] && !(pt_we && pt_page == hpage);

  assign req_ready = !walking;

  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hitv[i] = tv[i] && (tag[i] == rpage);
  end

  always_comb begin
    hfr = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hitv[i]) hfr = hfr | tfr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv        <= '0;
      pv        <= '0;
      walking   <= 1'b0;
      held      <= '0;
      rr        <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        tag[i] <= '0;
        tfr[i] <= '0;
      end
      for (int j = 0; j < PT_N; j++) pfr[j] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      if (accept) begin
        if (hit) begin
          rsp_valid <= 1'b1;
          rsp_paddr <= {hfr, req_vaddr[OFF_W-1:0]};
        end else begin
          walking <= 1'b1;
          held    <= req_vaddr;
        end
      end
      if (walking) begin
        walking   <= 1'b0;
        rsp_valid <= 1'b1;
        if (pv[hpage]) rsp_paddr <= {pfr[hpage], held[OFF_W-1:0]};
        else           rsp_fault <= 1'b1;
      end
      if (pt_we) begin
        pv[pt_page]  <= pt_valid;
        pfr[pt_page] <= pt_frame;
        for (int i = 0; i < TLB_N; i++)
          if (tag[i] == pt_page) tv[i] <= 1'b0;
      end
      if (refill) begin
        tv[rr]  <= 1'b1;
        tag[rr] <= hpage;
        tfr[rr] <= pfr[hpage];
        rr      <= (rr == RR_W'(TLB_N - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  p_hit_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_valid);
  p_miss_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> !rsp_valid);
  p_miss_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |-> ##2 rsp_valid);
  p_one_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> !req_ready);
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);
  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));
endmodule

// File: tb/xlate_unit_test.sv
`timescale 1ns/1ps
module xlate_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [12:0] req_vaddr = '0;
  logic        rsp_valid, rsp_fault;
  logic [11:0] rsp_paddr;
  logic        pt_we = 0;
  logic [2:0]  pt_page = '0;
  logic        pt_valid = 0;
  logic [1:0]  pt_frame = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit       m_pv [8];
  bit [1:0] m_pf [8];
  bit       m_tv [4];
  bit [2:0] m_tag[4];
  int       m_rr = 0;

  always #4 clk = ~clk;

  xlate_unit uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic pt_write(input bit [2:0] pg, input bit v, input bit [1:0] fr);
    @(negedge clk);
    pt_we = 1; pt_page = pg; pt_valid = v; pt_frame = fr;
    @(negedge clk);
    pt_we = 0;
    m_pv[pg] = v; m_pf[pg] = fr;
    for (int i = 0; i < 4; i++) if (m_tag[i] == pg) m_tv[i] = 0;
  endtask

  task automatic xlate(input bit [12:0] va, input string req);
    int lat;
    bit hit;
    bit [2:0] pg;
    pg = va[12:10];
    hit = 0;
    for (int i = 0; i < 4; i++) if (m_tv[i] && m_tag[i] == pg) hit = 1;
    @(negedge clk);
    check({req, " ready"}, req_ready, 1);
    req_valid = 1; req_vaddr = va;
    @(posedge clk);
    #1 req_valid = 0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1 && !hit) check("R9 ready low during miss", req_ready, 0);
    end while (!rsp_valid && lat < 8);
    check({req, " latency"}, lat, hit ? 1 : 2);
    if (hit || m_pv[pg]) begin
      check({req, " fault"}, rsp_fault, 0);
      check({req, " paddr"}, rsp_paddr, {m_pf[pg], va[9:0]});
    end else begin
      check({req, " R4 fault"}, rsp_fault, 1);
      check({req, " R4 paddr zero"}, rsp_paddr, 0);
    end
    if (!hit && m_pv[pg]) begin
      m_tv[m_rr] = 1; m_tag[m_rr] = pg; m_rr = (m_rr + 1) % 4;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    bit [9:0] offs [4];
    offs[0] = 10'h000; offs[1] = 10'h3FF; offs[2] = 10'h155;
    repeat (3) @(negedge clk);
    check("R8 ready after reset", req_ready, 1);
    check("R8 no response after reset", rsp_valid, 0);
    rst_n = 1;
    for (int p = 0; p < 8; p++) xlate({3'(p), 10'h0AB}, "R8 empty table faults");

    for (int p = 0; p < 8; p++) pt_write(3'(p), 1, 2'((p + 1) % 4));
    for (int r = 0; r < 3; r++)
      for (int p = 0; p < 8; p++) begin
        offs[3] = 10'(p * 37 + r);
        xlate({3'(p), offs[r]}, "R1 R2 R3 sweep");
        xlate({3'(p), offs[3]}, "R2 R3 repeat");
      end

    pt_write(3'd5, 1, 2'd1);
    xlate(13'h1553, "R1 example");
    check("R1 example value", rsp_paddr, 12'h553);
    xlate(13'h1553, "R2 example hit");

    for (int p = 0; p < 8; p++) pt_write(3'(p), 1, 2'(3 - (p % 4)));
    for (int p = 0; p < 5; p++) xlate({3'(p), 10'h010}, "R7 fill");
    xlate({3'd1, 10'h020}, "R7 second still held");
    xlate({3'd0, 10'h030}, "R7 first evicted");

    xlate({3'd2, 10'h111}, "R10 cache page");
    xlate({3'd2, 10'h111}, "R10 cached hit");
    pt_write(3'd2, 0, 2'd0);
    xlate({3'd2, 10'h111}, "R10 invalidated faults");
    pt_write(3'd2, 1, 2'd2);
    xlate({3'd2, 10'h111}, "R5 retry succeeds");

    xlate({3'd6, 10'h222}, "R6 cache page");
    pt_write(3'd6, 1, 2'd0);
    xlate({3'd6, 10'h222}, "R6 remapped frame");
    xlate({3'd6, 10'h223}, "R6 remapped hit");

    for (int p = 0; p < 8; p++) pt_write(3'(p), p[0], 2'(p));
    for (int p = 0; p < 8; p++) xlate({3'(p), 10'h3C3}, "R4 R3 mixed sweep");

    report();
  end
endmodule